// File: doc/BRIEF.md
# Shared Control Register Region with Layered Defaults

This block holds a small word-addressed register window that a host driver and a local controller share during device setup and control. Both sides read and write the same words. When a word has not been written since the last reset of the function, a read falls back through two layers of defaults: a device-level layer, then a type-level layer shared by every instance of the same device type, and finally zero.

Each host write marks its word as waiting for the local side and raises a notification. The notification stays up until the local side has read or overwritten every word the host touched, so a handler that services only part of the host's writes sees the event again. Device-level defaults are staged and only take effect at the next function-level reset pulse or at the next hotplug, which is the rising edge of the device-present input. Type-level defaults can only be programmed while no device is present.

The window is built from 64-byte blocks, one to four of them, and it starts on a 64-byte boundary in the BAR. With the default 32-bit words and four blocks it holds 64 words. Reads have one cycle of latency on both sides.

Top module: `stateful_bar_region`

## Requirements
- R1: After reset `host_rvalid`, `loc_rvalid` and `wr_event` are low, and every word reads as zero.
- R2: A read request on either side is answered one cycle later with its valid output high. A host write is returned by a host read of the same word issued in the very next cycle.
- R3: A read returns the value of whichever side wrote the word last. When host and local side write the same word in the same cycle, the host value is kept and the word stays marked as waiting.
- R4: A word not written since the last reset event reads as the active device default if one is set, otherwise the type default if one is set, otherwise zero.
- R5: A default write with `dflt_layer` = 0 stages a device default. Reads do not see it until a reset event copies the staged layer into the active layer. A reset event is `flr_pulse` high, or `dev_present` high after being low in the previous cycle.
- R6: A reset event drops every written value, so reads fall back to the defaults, and it clears the notification. Host and local writes issued in that same cycle are ignored.
- R7: A default write with `dflt_layer` = 1 programs the type default only while `dev_present` is low. While it is high the write has no effect.
- R8: A host write that is not ignored under R6 makes `wr_event` high in the following cycle.
- R9: `wr_event` stays high while any host-written word has not yet been read or written by the local side. A local read or write clears the mark of that word only. `wr_event` never rises without a host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flr_pulse | input | 1 | Function-level reset request, one cycle |
| dev_present | input | 1 | High while a device instance exists; a rising edge is a hotplug |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 6 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 32 | Host read data |
| loc_wr_en | input | 1 | Local write strobe |
| loc_rd_en | input | 1 | Local read strobe |
| loc_addr | input | 6 | Local word address |
| loc_wdata | input | 32 | Local write data |
| loc_rvalid | output | 1 | Local read data valid |
| loc_rdata | output | 32 | Local read data |
| dflt_wr_en | input | 1 | Default write strobe |
| dflt_layer | input | 1 | Default layer: 0 device (staged), 1 type |
| dflt_addr | input | 6 | Default word address |
| dflt_wdata | input | 32 | Default value |
| wr_event | output | 1 | Host write waiting for local service |

## Verification
The assertions assume the addresses stay inside the window and that the local side does not overwrite a word in the same cycle as the host writes it, except where the host is meant to win. The read-after-write property also assumes no reset event falls in the write cycle. The stimulus draws addresses from inside the window, mostly from a narrow pool so that collisions, fallbacks and re-raised events happen often. It fires reset pulses and presence changes only rarely, and the reference model in the bench follows the same host-over-local ordering as R3.

// File: rtl/sbr_pkg.sv
// Shared constants and types for the stateful BAR region.
// Assumes byte-sized data words (DATA_W a multiple of 8).
package sbr_pkg;
    localparam int BLOCK_BYTES = 64;   // size of one region block
    localparam int MAX_BLOCKS  = 4;    // largest region allowed

    // Selects which default layer a default write targets.
    typedef enum logic {
        LAYER_DEVICE = 1'b0,
        LAYER_TYPE   = 1'b1
    } dflt_layer_e;
endpackage

// File: rtl/sbr_value_store.sv
// Per-word storage of the last written value and a "written since reset" flag.
// Host write wins over a local write to the same word in the same cycle.
// Assumes clr_all and the write strobes are already qualified by the caller.
module sbr_value_store #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 64,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              loc_we,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] val_q [NUM_WORDS],
    output logic [NUM_WORDS-1:0] written_q
);
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam logic [ADDR_W-1:0] WIDX = ADDR_W'(i);
        // Update the word and its written flag; a reset event drops the flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q[i]     <= '0;
                written_q[i] <= 1'b0;
            end else if (clr_all) begin
                written_q[i] <= 1'b0;
            end else if (host_we && host_addr == WIDX) begin
                val_q[i]     <= host_wdata;
                written_q[i] <= 1'b1;
            end else if (loc_we && loc_addr == WIDX) begin
                val_q[i]     <= loc_wdata;
                written_q[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbr_default_layers.sv
// Device-level (staged plus active) and type-level default layers.
// Staged device defaults move to the active layer on apply; the active layer
// takes the staged contents from before any staged write in the same cycle.
// Type defaults are writable only while no device is present.
module sbr_default_layers
    import sbr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 64,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  logic              dev_present,
    input  logic              dflt_we,
    input  dflt_layer_e       dflt_layer,
    input  logic [ADDR_W-1:0] dflt_addr,
    input  logic [DATA_W-1:0] dflt_wdata,
    output logic [DATA_W-1:0] dev_val [NUM_WORDS],
    output logic [NUM_WORDS-1:0] dev_set,
    output logic [DATA_W-1:0] typ_val [NUM_WORDS],
    output logic [NUM_WORDS-1:0] typ_set
);
    logic [DATA_W-1:0]    stg_val [NUM_WORDS];
    logic [NUM_WORDS-1:0] stg_set;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam logic [ADDR_W-1:0] WIDX = ADDR_W'(i);
        logic hit;
        assign hit = dflt_we && dflt_addr == WIDX;

        // Hold the staged device default until the next reset event.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_val[i] <= '0;
                stg_set[i] <= 1'b0;
            end else if (hit && dflt_layer == LAYER_DEVICE) begin
                stg_val[i] <= dflt_wdata;
                stg_set[i] <= 1'b1;
            end
        end

        // Copy the staged device default into the active layer on apply.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dev_val[i] <= '0;
                dev_set[i] <= 1'b0;
            end else if (apply) begin
                dev_val[i] <= stg_val[i];
                dev_set[i] <= stg_set[i];
            end
        end

        // Program the type default while the type has no live device.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                typ_val[i] <= '0;
                typ_set[i] <= 1'b0;
            end else if (hit && dflt_layer == LAYER_TYPE && !dev_present) begin
                typ_val[i] <= dflt_wdata;
                typ_set[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sbr_dirty_track.sv
// Per-word marks of host writes not yet serviced by the local side.
// A host write sets a mark and overrides a local access in the same cycle.
module sbr_dirty_track #(
    parameter int NUM_WORDS = 64,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              loc_touch,
    input  logic [ADDR_W-1:0] loc_addr,
    output logic              any_dirty
);
    logic [NUM_WORDS-1:0] dirty_q;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam logic [ADDR_W-1:0] WIDX = ADDR_W'(i);
        // Set on host write, clear on local service or reset event.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                dirty_q[i] <= 1'b0;
            end else if (host_we && host_addr == WIDX) begin
                dirty_q[i] <= 1'b1;
            end else if (loc_touch && loc_addr == WIDX) begin
                dirty_q[i] <= 1'b0;
            end
        end
    end

    assign any_dirty = |dirty_q;
endmodule

// File: rtl/stateful_bar_region.sv
// Stateful register window shared by a host driver and a local controller.
// Reads resolve: last write, active device default, type default, zero.
// A reset event (FLR pulse or rising dev_present) drops written values,
// clears pending host-write marks and activates staged device defaults.
// Assumes single-cycle strobes; read data arrives one cycle after the request.
module stateful_bar_region
    import sbr_pkg::*;
#(
    parameter  int DATA_W     = 32,
    parameter  int NUM_BLOCKS = 4,
    localparam int NUM_WORDS  = NUM_BLOCKS * BLOCK_BYTES / (DATA_W / 8),
    localparam int ADDR_W     = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flr_pulse,
    input  logic              dev_present,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              loc_wr_en,
    input  logic              loc_rd_en,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic              loc_rvalid,
    output logic [DATA_W-1:0] loc_rdata,
    input  logic              dflt_wr_en,
    input  logic              dflt_layer,
    input  logic [ADDR_W-1:0] dflt_addr,
    input  logic [DATA_W-1:0] dflt_wdata,
    output logic              wr_event
);
    initial begin
        if (NUM_BLOCKS < 1 || NUM_BLOCKS > MAX_BLOCKS)
            $error("NUM_BLOCKS out of range");
    end

    logic                 present_q;
    logic                 reset_evt;
    logic                 host_we;
    logic                 loc_we;
    logic [DATA_W-1:0]    val_q   [NUM_WORDS];
    logic [DATA_W-1:0]    dev_val [NUM_WORDS];
    logic [DATA_W-1:0]    typ_val [NUM_WORDS];
    logic [NUM_WORDS-1:0] written_q;
    logic [NUM_WORDS-1:0] dev_set;
    logic [NUM_WORDS-1:0] typ_set;

    // Remember presence to detect a hotplug edge.
    always_ff @(posedge clk) begin
        if (!rst_n) present_q <= 1'b0;
        else        present_q <= dev_present;
    end

    assign reset_evt = flr_pulse || (dev_present && !present_q);
    assign host_we   = host_wr_en && !reset_evt;
    assign loc_we    = loc_wr_en && !reset_evt;

    sbr_value_store #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr_all(reset_evt),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .val_q(val_q), .written_q(written_q)
    );

    sbr_default_layers #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_dflt (
        .clk(clk), .rst_n(rst_n), .apply(reset_evt), .dev_present(dev_present),
        .dflt_we(dflt_wr_en), .dflt_layer(dflt_layer_e'(dflt_layer)),
        .dflt_addr(dflt_addr), .dflt_wdata(dflt_wdata),
        .dev_val(dev_val), .dev_set(dev_set), .typ_val(typ_val), .typ_set(typ_set)
    );

    sbr_dirty_track #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_dirty (
        .clk(clk), .rst_n(rst_n), .clr_all(reset_evt),
        .host_we(host_we), .host_addr(host_addr),
        .loc_touch(loc_wr_en || loc_rd_en), .loc_addr(loc_addr),
        .any_dirty(wr_event)
    );

    // Resolve one word through the layered fallback.
    function automatic logic [DATA_W-1:0] layered(input logic [ADDR_W-1:0] a);
        if (32'(a) >= NUM_WORDS) return '0;
        if (written_q[a])        return val_q[a];
        if (dev_set[a])          return dev_val[a];
        if (typ_set[a])          return typ_val[a];
        return '0;
    endfunction

    // Register host read responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= host_rd_en;
            if (host_rd_en) host_rdata <= layered(host_addr);
        end
    end

    // Register local read responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_rvalid <= 1'b0;
            loc_rdata  <= '0;
        end else begin
            loc_rvalid <= loc_rd_en;
            if (loc_rd_en) loc_rdata <= layered(loc_addr);
        end
    end
endmodule

// File: rtl/stateful_bar_region_chk.sv
// Port-level checks for stateful_bar_region, attached with bind.
// Assumes addresses inside the window.
module stateful_bar_region_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flr_pulse,
    input logic              dev_present,
    input logic              host_wr_en,
    input logic              host_rd_en,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              host_rvalid,
    input logic [DATA_W-1:0] host_rdata,
    input logic              loc_rd_en,
    input logic              loc_rvalid,
    input logic              wr_event
);
    logic              pres_q;
    logic              wq_ok;
    logic [ADDR_W-1:0] wq_addr;
    logic [DATA_W-1:0] wq_data;
    logic              evt_cyc;

    assign evt_cyc = flr_pulse || (dev_present && !pres_q);

    // Track the last accepted host write for the read-after-write check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_q  <= 1'b0;
            wq_ok   <= 1'b0;
            wq_addr <= '0;
            wq_data <= '0;
        end else begin
            pres_q  <= dev_present;
            wq_ok   <= host_wr_en && !evt_cyc;
            wq_addr <= host_addr;
            wq_data <= host_wdata;
        end
    end

    assert_host_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_en |=> host_rvalid);

    assert_loc_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rd_en |=> loc_rvalid);

    assert_read_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wq_ok && host_rd_en && host_addr == wq_addr) |=> host_rdata == $past(wq_data));

    assert_event_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && !evt_cyc) |=> wr_event);

    assert_no_spurious_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_event && !host_wr_en) |=> !wr_event);

    assert_reset_event_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cyc |=> !wr_event);
endmodule

bind stateful_bar_region stateful_bar_region_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flr_pulse(flr_pulse), .dev_present(dev_present),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .loc_rd_en(loc_rd_en), .loc_rvalid(loc_rvalid), .wr_event(wr_event)
);

// File: tb/tb_stateful_bar_region.sv
`timescale 1ns/1ps
module tb_stateful_bar_region;
    localparam int DW = 32;
    localparam int NW = 64;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          flr_pulse, dev_present;
    logic          host_wr_en, host_rd_en, host_rvalid;
    logic [AW-1:0] host_addr;
    logic [DW-1:0] host_wdata, host_rdata;
    logic          loc_wr_en, loc_rd_en, loc_rvalid;
    logic [AW-1:0] loc_addr;
    logic [DW-1:0] loc_wdata, loc_rdata;
    logic          dflt_wr_en, dflt_layer;
    logic [AW-1:0] dflt_addr;
    logic [DW-1:0] dflt_wdata;
    logic          wr_event;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    stateful_bar_region dut (
        .clk(clk), .rst_n(rst_n), .flr_pulse(flr_pulse), .dev_present(dev_present),
        .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .loc_wr_en(loc_wr_en), .loc_rd_en(loc_rd_en), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rvalid(loc_rvalid), .loc_rdata(loc_rdata),
        .dflt_wr_en(dflt_wr_en), .dflt_layer(dflt_layer), .dflt_addr(dflt_addr),
        .dflt_wdata(dflt_wdata), .wr_event(wr_event)
    );

    // Reference model state
    logic [DW-1:0] m_val [NW];
    logic [DW-1:0] m_stg [NW];
    logic [DW-1:0] m_dev [NW];
    logic [DW-1:0] m_typ [NW];
    logic [NW-1:0] m_wr, m_stg_set, m_dev_set, m_typ_set, m_dirty;
    logic          m_pres;

    function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
        if (m_wr[a])      return m_val[a];
        if (m_dev_set[a]) return m_dev[a];
        if (m_typ_set[a]) return m_typ[a];
        return '0;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < NW; i++) begin
            m_val[i] = '0; m_stg[i] = '0; m_dev[i] = '0; m_typ[i] = '0;
        end
        m_wr = '0; m_stg_set = '0; m_dev_set = '0; m_typ_set = '0; m_dirty = '0;
        m_pres = 1'b0;
    endtask

    task automatic m_step();
        bit evt;
        evt = flr_pulse || (dev_present && !m_pres);
        if (evt) begin
            for (int i = 0; i < NW; i++) m_dev[i] = m_stg[i];
            m_dev_set = m_stg_set;
            m_wr = '0;
            m_dirty = '0;
        end
        if (dflt_wr_en) begin
            if (dflt_layer == 1'b0) begin
                m_stg[dflt_addr] = dflt_wdata; m_stg_set[dflt_addr] = 1'b1;
            end else if (!dev_present) begin
                m_typ[dflt_addr] = dflt_wdata; m_typ_set[dflt_addr] = 1'b1;
            end
        end
        if (!evt) begin
            if (loc_wr_en) begin
                m_val[loc_addr] = loc_wdata; m_wr[loc_addr] = 1'b1;
            end
            if (loc_wr_en || loc_rd_en) m_dirty[loc_addr] = 1'b0;
            if (host_wr_en) begin
                m_val[host_addr] = host_wdata; m_wr[host_addr] = 1'b1;
                m_dirty[host_addr] = 1'b1;
            end
        end
        m_pres = dev_present;
    endtask

    task automatic check(input string req, input bit ok, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        host_wr_en = 0; host_rd_en = 0; host_addr = '0; host_wdata = '0;
        loc_wr_en = 0; loc_rd_en = 0; loc_addr = '0; loc_wdata = '0;
        dflt_wr_en = 0; dflt_layer = 0; dflt_addr = '0; dflt_wdata = '0;
        flr_pulse = 0;
    endtask

    // One clock: predict, advance, compare; leaves strobes idle.
    task automatic tick(input string req);
        logic [DW-1:0] eh, el;
        bit hr, lr;
        hr = host_rd_en; lr = loc_rd_en;
        eh = m_read(host_addr); el = m_read(loc_addr);
        m_step();
        @(posedge clk);
        @(negedge clk);
        check(req, host_rvalid == hr, {31'd0, host_rvalid}, {31'd0, hr});
        if (hr) check(req, host_rdata == eh, host_rdata, eh);
        if (lr) check(req, loc_rdata == el, loc_rdata, el);
        check("R9", wr_event == (|m_dirty), {31'd0, wr_event}, {31'd0, |m_dirty});
        idle_inputs();
    endtask

    task automatic hread(input logic [AW-1:0] a, input string req);
        host_rd_en = 1; host_addr = a; tick(req);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        dev_present = 0;
        rst_n = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        check("R1", !host_rvalid && !loc_rvalid && !wr_event, {29'd0, host_rvalid, loc_rvalid, wr_event}, '0);
        hread(6'd0, "R1");
        loc_rd_en = 1; loc_addr = 6'd63; tick("R1");

        // R7 / R4: type default while absent
        dflt_wr_en = 1; dflt_layer = 1; dflt_addr = 6'd2; dflt_wdata = 32'hA0A0_0002; tick("R7");
        hread(6'd2, "R4");
        hread(6'd3, "R4");
        // R5: staged device default not visible yet
        dflt_wr_en = 1; dflt_layer = 0; dflt_addr = 6'd2; dflt_wdata = 32'hB0B0_0002; tick("R5");
        hread(6'd2, "R5");
        dev_present = 1; tick("R5");           // hotplug applies staged layer
        hread(6'd2, "R5");
        // R7: type write ignored while present
        dflt_wr_en = 1; dflt_layer = 1; dflt_addr = 6'd4; dflt_wdata = 32'hC0C0_0004; tick("R7");
        hread(6'd4, "R7");
        // R2 / R8: host write then immediate read
        host_wr_en = 1; host_addr = 6'd2; host_wdata = 32'hD0D0_0002; tick("R8");
        hread(6'd2, "R2");
        // R3: local overwrite wins later; clears event
        loc_wr_en = 1; loc_addr = 6'd2; loc_wdata = 32'hE0E0_0002; tick("R3");
        hread(6'd2, "R3");
        // R3: same-cycle collision, host kept and word stays waiting
        host_wr_en = 1; host_addr = 6'd6; host_wdata = 32'hF0F0_0006;
        loc_wr_en = 1; loc_addr = 6'd6; loc_wdata = 32'h1111_0006; tick("R3");
        hread(6'd6, "R3");
        loc_rd_en = 1; loc_addr = 6'd6; tick("R9");
        // R9: partial service keeps event high
        host_wr_en = 1; host_addr = 6'd3; host_wdata = 32'h0000_0033; tick("R8");
        host_wr_en = 1; host_addr = 6'd5; host_wdata = 32'h0000_0055; tick("R8");
        loc_rd_en = 1; loc_addr = 6'd3; tick("R9");
        loc_wr_en = 1; loc_addr = 6'd5; loc_wdata = 32'h0000_0505; tick("R9");
        // R6: FLR drops writes and clears event; write in same cycle ignored
        host_wr_en = 1; host_addr = 6'd2; host_wdata = 32'h2222_2222; tick("R8");
        flr_pulse = 1; host_wr_en = 1; host_addr = 6'd7; host_wdata = 32'h7777_7777; tick("R6");
        hread(6'd2, "R6");
        hread(6'd7, "R6");

        // Random phase
        for (int k = 0; k < 4000; k++) begin
            logic [AW-1:0] pick;
            if ($urandom_range(99) < 30) begin
                host_wr_en = 1; host_wdata = $urandom;
            end
            if ($urandom_range(99) < 50) host_rd_en = 1;
            pick = ($urandom_range(3) == 0) ? AW'($urandom_range(NW-1)) : AW'($urandom_range(7));
            host_addr = pick;
            if ($urandom_range(99) < 12) begin
                loc_wr_en = 1; loc_wdata = $urandom;
            end
            if ($urandom_range(99) < 25) loc_rd_en = 1;
            loc_addr = AW'($urandom_range(7));
            if ($urandom_range(99) < 10) begin
                dflt_wr_en = 1; dflt_layer = 1'($urandom_range(1));
                dflt_addr = AW'($urandom_range(7)); dflt_wdata = $urandom;
            end
            if ($urandom_range(99) < 2) flr_pulse = 1;
            if ($urandom_range(99) < 1) dev_present = ~dev_present;
            tick("R4");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule